// File: doc/BRIEF.md
# System Clock Reference Counter Unit

This block keeps the 32-bit time base of a media decoder. A host reaches it through a byte-wide register port. The counter steps once per count-enable pulse, which stands in for the slow reference tick. A read of the low counter byte freezes the three upper bytes into holding registers, so the host can assemble a coherent 32-bit value from four byte reads. To load a new time, the host sets a pause bit, writes the four value bytes and clears the bit. The counter takes the written value and counts on from there.

Two compare targets run beside the counter. The compare/capture target drives a video autostart strobe and the audio target drives an audio autostart strobe. Each match raises a sticky compare interrupt and emits a single one-cycle strobe. In capture mode the compare/capture target instead latches the counter when a chosen event strobe fires. A wrap from all ones to zero raises a sticky overflow interrupt. The active-low interrupt line reflects every status bit that is not masked.

The counter control machine has two states. In `CNT_RUN` a tick advances the count while the pause bit is clear. The transition RUN→HALT is taken when the pause bit is seen set. The transition HALT→RUN is taken when the pause bit is seen clear, and on that step the holding bytes are copied into the counter. Each compare unit also has two states. `MT_ARMED` can fire. The transition ARMED→SPENT follows a match that is not accompanied by a counter update. The transition SPENT→ARMED follows any counter update, either an increment or a load.

Top module: `scr_unit`

## Requirements
- R1: After reset every register reads zero and irq_n is high. The control register sits at address 0 and reads back as written in bits 6:0. Its fields are: bit0 pause; bits 2:1 mode, where 0 is none, 1 is compare, 2 is capture and 3 acts as none; bits 4:3 event select, where 0 is picture start, 1 is audio sync, 2 is video timestamp and 3 is divided clock; bit5 video autostart enable; bit6 audio autostart enable. Status is at address 1 (bit0 overflow, bit1 compare) and the mask is at address 2 (same bits, 1 masks). The counter bytes are at 4–7, the compare/capture target at 8–11 and the audio target at 12–15, each with the low byte at the lowest address.
- R2: A read of address 4 returns the live low counter byte. In that same cycle it copies counter bits 31:8 into the holding bytes that addresses 5–7 return. Those bytes keep the copied value until the next read of address 4.
- R3: Writes to addresses 4–7 change only the holding bytes. The counter takes the whole holding value on the clock edge after the write that clears the pause bit, and it counts up from that value afterwards.
- R4: With the pause bit clear, each cycle with cnt_tick high adds one to the counter. With the pause bit set (from the cycle after the write that sets it), ticks are ignored.
- R5: A tick that wraps the counter from all ones to zero sets status bit0 on that same edge.
- R6: Status bits are sticky. Writing one to a status bit clears it, and a new event in the same cycle wins over the clear. irq_n is low exactly when some status bit is set and its mask bit is 0.
- R7: In compare mode, equality between the counter and the compare/capture target sets status bit1 and, if bit5 is set, pulses vid_start. Equality with the audio target sets status bit1 and, if bit6 is set, pulses aud_start. The flag and the strobe appear on the edge after the counter reaches the value.
- R8: A match gives exactly one one-cycle strobe, however long the counter holds the matching value. It can fire again only after the counter is incremented or loaded.
- R9: In capture mode, a high cycle on the selected event input copies the counter into the compare/capture target on that edge. Unselected event inputs are ignored.
- R10: In modes none and reserved, matches raise neither status bit1 nor any strobe, and event inputs do not change the compare/capture target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effect on address 4) |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| cnt_tick | input | 1 | Count-enable pulse |
| ev_picture | input | 1 | Picture start event strobe |
| ev_audsync | input | 1 | Audio sync event strobe |
| ev_vdts | input | 1 | Video decode timestamp event strobe |
| ev_divclk | input | 1 | Divided clock event strobe |
| irq_n | output | 1 | Active-low interrupt |
| aud_start | output | 1 | Audio autostart strobe |
| vid_start | output | 1 | Video autostart strobe |

## Verification
Assertions check on every cycle the relations that hold locally. A set pause bit freezes the counter, a load copies the holding value and a wrap lands on zero. A low-byte read snapshots the upper bytes, a captured target equals the counter, status bits stay sticky, and a strobe follows only a match and never repeats while the value stands still. The bench scenarios show what needs a sequence of host operations. These are the coherent four-byte read while ticks continue, staged writes that stay out of the counter until the unpause, the interrupt line under masking and clearing, per-channel strobe enables, event selection, and the silence of the none and reserved modes. A seeded random mix of ticks, loads near the wrap point, reads and clears is compared against a bench model.

// File: rtl/scr_pkg.sv
`timescale 1ns/1ps
package scr_pkg;

    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,
        MODE_CMP  = 2'd1,
        MODE_CAP  = 2'd2,
        MODE_RSV  = 2'd3
    } scr_mode_e;

    typedef enum logic [1:0] {
        EV_PICTURE = 2'd0,
        EV_AUDSYNC = 2'd1,
        EV_VDTS    = 2'd2,
        EV_DIVCLK  = 2'd3
    } ev_sel_e;

    // bit6 aud_en, bit5 vid_en, bits4:3 evsel, bits2:1 mode, bit0 pause
    typedef struct packed {
        logic      aud_en;
        logic      vid_en;
        ev_sel_e   evsel;
        scr_mode_e mode;
        logic      pause;
    } scr_ctrl_t;

    localparam int IRQ_OVF = 0;
    localparam int IRQ_CMP = 1;
    localparam int N_IRQ   = 2;
    localparam int N_MATCH = 2;   // index 0 video, 1 audio

    typedef enum logic {
        CNT_RUN  = 1'b0,
        CNT_HALT = 1'b1
    } cnt_state_e;

    typedef enum logic {
        MT_ARMED = 1'b0,
        MT_SPENT = 1'b1
    } mt_state_e;

endpackage

// File: rtl/scr_counter.sv
`timescale 1ns/1ps
module scr_counter
    import scr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int NB    = CNT_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pause,
    input  logic [NB-1:0]    hold_we,
    input  logic [7:0]       wbyte,
    input  logic             snap,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] hold,
    output logic             chg,
    output logic             wrap
);

    cnt_state_e       st_q, st_d;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] hold_q;
    logic             inc;
    logic             load;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CNT_RUN;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CNT_RUN:  if (pause)  st_d = CNT_HALT;
            CNT_HALT: if (!pause) st_d = CNT_RUN;
            default:  st_d = CNT_RUN;
        endcase
    end

    // outputs of the control machine
    always_comb begin
        inc  = 1'b0;
        load = 1'b0;
        unique case (st_q)
            CNT_RUN:  inc  = tick && !pause;
            CNT_HALT: load = !pause;
            default:  ;
        endcase
    end

    assign wrap = inc && (&count_q);
    assign chg  = inc || load;

    always_ff @(posedge clk) begin
        if (!rst_n)    count_q <= '0;
        else if (load) count_q <= hold_q;
        else if (inc)  count_q <= count_q + CNT_W'(1);
    end

    // holding bytes: host staging and read snapshot
    for (genvar b = 0; b < NB; b++) begin : g_hold
        if (b == 0) begin : g_low
            always_ff @(posedge clk) begin
                if (!rst_n)          hold_q[7:0] <= '0;
                else if (hold_we[0]) hold_q[7:0] <= wbyte;
            end
        end else begin : g_up
            always_ff @(posedge clk) begin
                if (!rst_n)          hold_q[b*8 +: 8] <= '0;
                else if (hold_we[b]) hold_q[b*8 +: 8] <= wbyte;
                else if (snap)       hold_q[b*8 +: 8] <= count_q[b*8 +: 8];
            end
        end
    end

    assign count = count_q;
    assign hold  = hold_q;

    AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        pause |=> $stable(count_q));                                   // R4
    AST_LOAD_TAKES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_q == $past(hold_q)));                          // R3
    AST_SNAP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (snap && !(|hold_we)) |=> (hold_q[CNT_W-1:8] == $past(count_q[CNT_W-1:8]))); // R2
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count_q == '0));                                     // R5

endmodule

// File: rtl/scr_match.sv
`timescale 1ns/1ps
module scr_match
    import scr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] target,
    input  logic             chg,
    output logic             hit,
    output logic             fire
);

    mt_state_e st_q, st_d;
    logic      fire_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= MT_ARMED;
        else        st_d_reg_update: st_q <= st_d;
    end

    // any counter update re-arms; a match on a standing value spends it
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MT_ARMED: if (hit && !chg) st_d = MT_SPENT;
            MT_SPENT: if (chg)         st_d = MT_ARMED;
            default:  st_d = MT_ARMED;
        endcase
    end

    always_comb begin
        hit = 1'b0;
        unique case (st_q)
            MT_ARMED: hit = en && (count == target);
            MT_SPENT: hit = 1'b0;
            default:  hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fire_q <= 1'b0;
        else        fire_q <= hit;
    end

    assign fire = fire_q;

    AST_FIRE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |-> $past(en && (count == target)));                    // R7
    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !chg) |=> !hit);                                       // R8

endmodule

// File: rtl/scr_irq.sv
`timescale 1ns/1ps
module scr_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic         mask_we,
    input  logic [N-1:0] mask_d,
    output logic [N-1:0] status,
    output logic [N-1:0] mask,
    output logic         irq_n
);

    logic [N-1:0] stat_q;
    logic [N-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_d;
    end

    assign irq_n  = ~|(stat_q & ~mask_q);
    assign status = stat_q;
    assign mask   = mask_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[i] && !clr[i]) |=> stat_q[i]);                     // R6
        AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> stat_q[i]);                                     // R6
    end

endmodule

// File: rtl/scr_unit.sv
`timescale 1ns/1ps
module scr_unit
    import scr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = $clog2(CNT_W / 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              cnt_tick,
    input  logic              ev_picture,
    input  logic              ev_audsync,
    input  logic              ev_vdts,
    input  logic              ev_divclk,
    output logic              irq_n,
    output logic              aud_start,
    output logic              vid_start
);

    localparam int NB       = CNT_W / 8;
    localparam int A_CTRL   = 0;
    localparam int A_STAT   = 1;
    localparam int A_MASK   = 2;
    localparam int VAL_BASE = NB;
    localparam int CMP_BASE = 2 * NB;
    localparam int AUD_BASE = 3 * NB;

    int               addr_i;
    logic             wr_ctrl, wr_stat, wr_mask, snap;
    logic [NB-1:0]    val_we, cmp_we, aud_we;
    scr_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] cmp_q, aud_q;
    logic [CNT_W-1:0] count, hold;
    logic             chg, wrap;
    logic [3:0]       ev_vec;
    logic             cap_hit, cmp_en;
    logic [N_MATCH-1:0]            m_hit, m_fire;
    logic [N_MATCH-1:0][CNT_W-1:0] m_tgt;
    logic [N_IRQ-1:0] irq_set, irq_clr, irq_stat, irq_mask;

    // address decode
    assign addr_i  = int'(host_addr);
    assign wr_ctrl = host_wr && (addr_i == A_CTRL);
    assign wr_stat = host_wr && (addr_i == A_STAT);
    assign wr_mask = host_wr && (addr_i == A_MASK);
    assign snap    = host_rd && !host_wr && (addr_i == VAL_BASE);

    for (genvar b = 0; b < NB; b++) begin : g_dec
        assign val_we[b] = host_wr && (addr_i == VAL_BASE + b);
        assign cmp_we[b] = host_wr && (addr_i == CMP_BASE + b);
        assign aud_we[b] = host_wr && (addr_i == AUD_BASE + b);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= scr_ctrl_t'(host_wdata[6:0]);
    end

    // event selection and capture
    assign ev_vec  = {ev_divclk, ev_vdts, ev_audsync, ev_picture};
    assign cap_hit = (ctrl_q.mode == MODE_CAP) && ev_vec[ctrl_q.evsel];
    assign cmp_en  = (ctrl_q.mode == MODE_CMP);

    for (genvar b = 0; b < NB; b++) begin : g_tgt
        always_ff @(posedge clk) begin
            if (!rst_n)         cmp_q[b*8 +: 8] <= '0;
            else if (cap_hit)   cmp_q[b*8 +: 8] <= count[b*8 +: 8];
            else if (cmp_we[b]) cmp_q[b*8 +: 8] <= host_wdata;
        end
        always_ff @(posedge clk) begin
            if (!rst_n)         aud_q[b*8 +: 8] <= '0;
            else if (aud_we[b]) aud_q[b*8 +: 8] <= host_wdata;
        end
    end

    scr_counter #(.CNT_W(CNT_W), .NB(NB)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (cnt_tick),
        .pause   (ctrl_q.pause),
        .hold_we (val_we),
        .wbyte   (host_wdata),
        .snap    (snap),
        .count   (count),
        .hold    (hold),
        .chg     (chg),
        .wrap    (wrap)
    );

    assign m_tgt[0] = cmp_q;
    assign m_tgt[1] = aud_q;

    for (genvar g = 0; g < N_MATCH; g++) begin : g_match
        scr_match #(.CNT_W(CNT_W)) u_match (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (cmp_en),
            .count  (count),
            .target (m_tgt[g]),
            .chg    (chg),
            .hit    (m_hit[g]),
            .fire   (m_fire[g])
        );
    end

    assign vid_start = m_fire[0] && ctrl_q.vid_en;
    assign aud_start = m_fire[1] && ctrl_q.aud_en;

    assign irq_set[IRQ_OVF] = wrap;
    assign irq_set[IRQ_CMP] = |m_hit;
    assign irq_clr          = wr_stat ? host_wdata[N_IRQ-1:0] : '0;

    scr_irq #(.N(N_IRQ)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (irq_set),
        .clr     (irq_clr),
        .mask_we (wr_mask),
        .mask_d  (host_wdata[N_IRQ-1:0]),
        .status  (irq_stat),
        .mask    (irq_mask),
        .irq_n   (irq_n)
    );

    // read mux
    always_comb begin
        host_rdata = '0;
        if (addr_i == A_CTRL) host_rdata = 8'(ctrl_q);
        if (addr_i == A_STAT) host_rdata = 8'(irq_stat);
        if (addr_i == A_MASK) host_rdata = 8'(irq_mask);
        for (int b = 0; b < NB; b++) begin
            if (addr_i == VAL_BASE + b) host_rdata = (b == 0) ? count[7:0] : hold[b*8 +: 8];
            if (addr_i == CMP_BASE + b) host_rdata = cmp_q[b*8 +: 8];
            if (addr_i == AUD_BASE + b) host_rdata = aud_q[b*8 +: 8];
        end
    end

    AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> (cmp_q == $past(count)));                          // R9
    AST_QUIET_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.mode != MODE_CMP) |-> !(|m_hit));                      // R10
    AST_CAPTURE_ONLY_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q.mode != MODE_CAP) && !(|cmp_we)) |=> $stable(cmp_q)); // R10

endmodule

// File: tb/scr_unit_tb.sv
`timescale 1ns/1ps
module scr_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       h_wr, h_rd;
    logic [3:0] h_addr;
    logic [7:0] h_wdata, h_rdata;
    logic       tick, e_pic, e_async, e_dts, e_div;
    logic       irq_n, aud_start, vid_start;

    always #5 clk = ~clk;

    scr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(h_wr), .host_rd(h_rd),
        .host_addr(h_addr), .host_wdata(h_wdata), .host_rdata(h_rdata),
        .cnt_tick(tick), .ev_picture(e_pic), .ev_audsync(e_async),
        .ev_vdts(e_dts), .ev_divclk(e_div), .irq_n(irq_n),
        .aud_start(aud_start), .vid_start(vid_start)
    );

    int checks = 0;
    int errors = 0;
    int vid_pulses = 0;
    int aud_pulses = 0;

    logic [31:0] m_cnt, m_hold;
    logic [7:0]  m_ctrl;
    logic [1:0]  m_stat, m_mask;

    always @(negedge clk) begin
        if (rst_n) begin
            if (vid_start) vid_pulses++;
            if (aud_start) aud_pulses++;
        end
    end

    function automatic logic [31:0] step_count(logic [31:0] c, logic paused);
        return paused ? c : c + 32'd1;
    endfunction

    function automatic logic exp_irq_n(logic [1:0] st, logic [1:0] mk);
        return !(|(st & ~mk));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        h_wr = 1'b1; h_addr = 4'(a); h_wdata = d;
        @(negedge clk);
        h_wr = 1'b0;
        if (a == 0) begin
            if (m_ctrl[0] && !d[0]) m_cnt = m_hold;
            m_ctrl = {1'b0, d[6:0]};
        end
        if (a == 1) m_stat = m_stat & ~d[1:0];
        if (a == 2) m_mask = d[1:0];
        if (a >= 4 && a <= 7) m_hold[(a-4)*8 +: 8] = d;
    endtask

    task automatic rd(int a, output logic [7:0] d);
        @(negedge clk);
        h_rd = 1'b1; h_addr = 4'(a);
        #1 d = h_rdata;
        @(negedge clk);
        h_rd = 1'b0;
        if (a == 4) m_hold[31:8] = m_cnt[31:8];
    endtask

    task automatic rd32(int base, output logic [31:0] v);
        logic [7:0] b;
        for (int k = 0; k < 4; k++) begin
            rd(base + k, b);
            v[k*8 +: 8] = b;
        end
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            if (!m_ctrl[0] && m_cnt == 32'hFFFF_FFFF) m_stat[0] = 1'b1;
            m_cnt = step_count(m_cnt, m_ctrl[0]);
        end
    endtask

    task automatic load_cnt(logic [31:0] v);
        wr(0, m_ctrl | 8'h01);
        for (int k = 0; k < 4; k++) wr(4 + k, v[k*8 +: 8]);
        wr(0, m_ctrl & 8'hFE);
    endtask

    task automatic wr32(int base, logic [31:0] v);
        for (int k = 0; k < 4; k++) wr(base + k, v[k*8 +: 8]);
    endtask

    task automatic pulse_ev(int which);
        @(negedge clk);
        case (which)
            0: e_pic = 1'b1;
            1: e_async = 1'b1;
            2: e_dts = 1'b1;
            default: e_div = 1'b1;
        endcase
        @(negedge clk);
        e_pic = 1'b0; e_async = 1'b0; e_dts = 1'b0; e_div = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  b;
        int          vb, ab, seed;
        seed = $urandom(32'd20240611);
        rst_n = 1'b0; h_wr = 0; h_rd = 0; h_addr = 0; h_wdata = 0;
        tick = 0; e_pic = 0; e_async = 0; e_dts = 0; e_div = 0;
        m_cnt = 0; m_hold = 0; m_ctrl = 0; m_stat = 0; m_mask = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state and control layout
        rd(0, b);   check("R1 ctrl reset", 32'(b), 0);
        rd(1, b);   check("R1 status reset", 32'(b), 0);
        #1 check("R1 irq_n reset", 32'(irq_n), 1);
        rd32(4, v); check("R1 counter reset", v, 0);
        wr(0, 8'h7E); rd(0, b); check("R1 ctrl readback", 32'(b), 32'h7E);
        wr(0, 8'h00);

        // R4 counting
        ticks(5);
        rd32(4, v); check("R4 five ticks", v, m_cnt);

        // R2 coherent snapshot across a carry
        load_cnt(32'h0000_00FF);
        rd(4, b);   check("R2 live low", 32'(b), 32'hFF);
        ticks(1);
        rd(5, b);   check("R2 snap byte1 frozen", 32'(b), 0);
        rd(4, b);   check("R2 live low after carry", 32'(b), 0);
        rd(5, b);   check("R2 byte1 after new snap", 32'(b), 1);

        // R4 pause freezes, R3 load on unpause
        wr(0, 8'h01);
        ticks(3);
        rd32(4, v); check("R4 paused no count", v, 32'h0000_0100);
        wr32(4, 32'hCAFE_0042);
        wr(0, 8'h00);
        rd32(4, v); check("R3 loaded value", v, 32'hCAFE_0042);
        ticks(2);
        rd32(4, v); check("R3 counts from loaded", v, 32'hCAFE_0044);

        // R3 staging writes while running stay out of the counter
        wr32(4, 32'h4433_2211);
        ticks(2);
        rd32(4, v); check("R3 running writes ignored", v, m_cnt);
        wr(0, 8'h01); wr(0, 8'h00);
        rd32(4, v); check("R3 unpause takes staged low byte", v, m_cnt);

        // R5 / R6 overflow interrupt
        load_cnt(32'hFFFF_FFFE);
        ticks(1);
        rd(1, b);   check("R5 no flag before wrap", 32'(b), 0);
        ticks(1);
        rd(1, b);   check("R5 flag on wrap", 32'(b), 1);
        rd32(4, v); check("R5 wraps to zero", v, 0);
        #1 check("R6 irq_n asserted", 32'(irq_n), 0);
        wr(2, 8'h01);
        #1 check("R6 masked irq_n", 32'(irq_n), 1);
        rd(1, b);   check("R6 sticky under mask", 32'(b), 1);
        wr(1, 8'h01);
        rd(1, b);   check("R6 write-one clears", 32'(b), 0);
        wr(2, 8'h00);

        // R7 / R8 compare strobes
        wr(0, 8'h00);
        wr32(8, 32'h20); wr32(12, 32'h22);
        load_cnt(32'h1E);
        wr(0, 8'h62);
        vb = vid_pulses; ab = aud_pulses;
        ticks(6); settle();
        check("R7 R8 one video strobe", 32'(vid_pulses - vb), 1);
        check("R7 R8 one audio strobe", 32'(aud_pulses - ab), 1);
        rd(1, b);   check("R7 compare flag", 32'(b), 2);
        #1 check("R7 irq_n on compare", 32'(irq_n), 0);
        wr(1, 8'h02);
        wr(0, 8'h00);
        load_cnt(32'h1E);
        wr(0, 8'h42);
        vb = vid_pulses; ab = aud_pulses;
        ticks(6); settle();
        check("R7 video disabled", 32'(vid_pulses - vb), 0);
        check("R7 audio still fires", 32'(aud_pulses - ab), 1);
        rd(1, b);   check("R7 flag without strobe enable", 32'(b), 2);
        wr(1, 8'h02);

        // R8 standing match fires once
        wr(0, 8'h00);
        load_cnt(32'h20);
        vb = vid_pulses;
        wr(0, 8'h62);
        repeat (10) @(negedge clk);
        check("R8 standing value single strobe", 32'(vid_pulses - vb), 1);
        ticks(1); settle();
        check("R8 no refire after change", 32'(vid_pulses - vb), 1);
        wr(1, 8'h02);

        // R9 capture
        wr(0, 8'h00);
        load_cnt(32'h1234_5678);
        wr(0, 8'h14);
        pulse_ev(0);
        rd32(8, v); check("R9 unselected event ignored", v, 32'h20);
        pulse_ev(2);
        rd32(8, v); check("R9 selected event captures", v, 32'h1234_5678);

        // R10 reserved and none modes are quiet
        wr(0, 8'h36);
        ticks(2);
        pulse_ev(2);
        rd32(8, v); check("R10 no capture in reserved", v, 32'h1234_5678);
        wr(0, 8'h00);
        load_cnt(32'h1234_5678);
        vb = vid_pulses;
        wr(0, 8'h76);
        settle();
        check("R10 no strobe in reserved", 32'(vid_pulses - vb), 0);
        rd(1, b);   check("R10 no compare flag", 32'(b), 0);
        wr(0, 8'h00);

        // seeded random mix against the model
        for (int it = 0; it < 150; it++) begin
            case ($urandom_range(0, 4))
                0: ticks($urandom_range(1, 6));
                1: load_cnt(($urandom_range(0, 1) == 1) ? (32'hFFFF_FFFF - 32'($urandom_range(0, 4)))
                                                        : $urandom);
                2: begin
                    rd32(4, v); check("R4 random count", v, m_cnt);
                end
                3: begin
                    rd(1, b); check("R5 random status", 32'(b), 32'(m_stat));
                    #1 check("R6 random irq_n", 32'(irq_n), 32'(exp_irq_n(m_stat, m_mask)));
                    wr(1, 8'($urandom_range(0, 3)));
                end
                default: wr(2, 8'($urandom_range(0, 3)));
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule